// File: doc/BRIEF.md
# Bus Master Tenure Controller

This block is the initiator-side controller that decides when a bus master may begin a transaction and when it must give the bus back. A burst request, carrying a count of data phases, is accepted over a valid/ready handshake. The controller then waits until the arbiter grants the bus and the shared bus shows no frame and no ready activity. Only then does it start the transaction and drive its own frame indication.

While it owns the bus, the controller holds a tenure down-counter. The counter is loaded with the guaranteed minimum number of owned cycles and counts down once per owned clock, stopping at zero. If the grant is withdrawn, the counter value decides what happens next. When the counter is already at zero, the master releases after the data phase in progress. When it is still positive, the master keeps transferring until the counter expires and then releases.

Each release produces a one-cycle pulse that reports the number of data phases actually transferred and whether the burst was cut short. A truncated burst can then be reissued as a new request for the remaining phases. The request handshake applies back-pressure: `req_ready_o` stays low from the accepting edge until the release cycle. A request offered during that time is neither stored nor acted on.

Top module: `tenure_ctrl`

## Requirements
- R1: `req_ready_o` is high exactly when no request is pending or running; a request is taken on a clock edge where `req_valid_i` and `req_ready_o` are both high, and a length of 0 is treated as 1 data phase.
- R2: The transaction starts only on an edge where `gnt_i` is high and both `bus_frame_i` and `bus_rdy_i` are low; `start_o` is then high for exactly the following cycle, in which `frame_o` rises.
- R3: While a request waits, no start happens for as long as the grant is low or the bus shows frame or ready activity.
- R4: At the start, the tenure counter loads `lat_value_i`; it decreases by one on every owned clock and holds at zero rather than wrapping.
- R5: Without loss of grant, `frame_o` stays high until the requested number of data phases have completed; a data phase completes on an owned cycle with `tgt_ready_i` high.
- R6: If the grant is low in an owned cycle while the tenure counter is zero, the master releases after the first data phase that completes from that cycle on.
- R7: If the grant is removed while the tenure counter is positive, transfers continue; the master releases after the first data phase that completes in a cycle where the counter has reached zero.
- R8: Once the grant has been seen low during a tenure, the loss is kept until the release, even if the grant returns.
- R9: `release_o` is a one-cycle pulse in the cycle after the last data phase, with `frame_o` low. In that cycle `rel_count_o` gives the number of data phases transferred and `rel_cut_o` is 1 if that number is below the requested length; both values hold until the next release.
- R10: In an owned cycle with `tgt_ready_i` low, no data phase is counted and `frame_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Burst request offered |
| req_ready_o | output | 1 | Controller can take a request |
| req_len_i | input | LEN_W | Requested number of data phases |
| lat_value_i | input | LAT_W | Guaranteed minimum tenure in cycles |
| gnt_i | input | 1 | Grant from the arbiter, active high |
| bus_frame_i | input | 1 | Another frame active on the bus |
| bus_rdy_i | input | 1 | Ready activity on the bus |
| tgt_ready_i | input | 1 | Target completes the current data phase |
| start_o | output | 1 | One-cycle pulse on the first owned cycle |
| frame_o | output | 1 | Master owns the bus |
| release_o | output | 1 | One-cycle pulse after the bus is released |
| rel_count_o | output | LEN_W | Data phases transferred in the last tenure |
| rel_cut_o | output | 1 | Last tenure ended before its requested length |

## Verification
The hardest case to reach is a grant removed while the tenure counter is still positive, because the release must fall exactly in the cycle where the counter has reached zero. The stimulus waits for the `start_o` pulse and drops the grant in that same cycle or a fixed number of cycles later. This makes the release cycle, and so the reported phase count, a hand-computable function of `lat_value_i`. A brief grant dip that recovers at once checks that the loss is remembered. A long burst with a small tenure value, preempted well after the counter has run out, shows that the counter held at zero instead of wrapping.

// File: rtl/tenure_pkg.sv
package tenure_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_XFER = 2'd2
  } tenure_st_e;
endpackage

// File: rtl/tenure_lat_counter.sv
module tenure_lat_counter #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LAT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic [LAT_W-1:0] cnt_o,
  output logic             expired_o
);
  localparam logic [LAT_W-1:0] ZERO = '0;
  localparam logic [LAT_W-1:0] ONE  = LAT_W'(1);

  logic [LAT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= ZERO;
    else if (load_i)                  cnt_q <= load_val_i;
    else if (run_i && cnt_q != ZERO)  cnt_q <= cnt_q - ONE;
  end

  assign cnt_o     = cnt_q;
  assign expired_o = (cnt_q == ZERO);

  // R4: the counter takes the guaranteed tenure value when loaded
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));
  // R4: one step down per owned clock
  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && cnt_o != ZERO) |=> cnt_o == $past(cnt_o) - ONE);
  // R4: holds at zero, never wraps
  assert_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_o == ZERO) |=> cnt_o == ZERO);
endmodule

// File: rtl/tenure_beat_counter.sv
module tenure_beat_counter #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             beat_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] count_o,
  output logic [LEN_W-1:0] next_o,
  output logic             last_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] count_q;

  assign next_o  = beat_i ? count_q + ONE : count_q;
  assign last_o  = beat_i && (next_o == len_i);
  assign count_o = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count_q <= '0;
    else if (clear_i) count_q <= '0;
    else              count_q <= next_o;
  end

  // R10: a cycle without a completed data phase leaves the count unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && !beat_i) |=> $stable(count_o));
  // R5: each completed data phase adds exactly one
  assert_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear_i && beat_i) |=> count_o == $past(count_o) + ONE);
endmodule

// File: rtl/tenure_start_gate.sv
module tenure_start_gate (
  input  logic armed_i,
  input  logic gnt_i,
  input  logic bus_frame_i,
  input  logic bus_rdy_i,
  output logic go_o
);
  logic bus_idle;
  assign bus_idle = !bus_frame_i && !bus_rdy_i;
  assign go_o     = armed_i && gnt_i && bus_idle;
endmodule

// File: rtl/tenure_ctrl.sv
module tenure_ctrl
  import tenure_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [LAT_W-1:0] lat_value_i,
  input  logic             gnt_i,
  input  logic             bus_frame_i,
  input  logic             bus_rdy_i,
  input  logic             tgt_ready_i,
  output logic             start_o,
  output logic             frame_o,
  output logic             release_o,
  output logic [LEN_W-1:0] rel_count_o,
  output logic             rel_cut_o
);
  localparam logic [LEN_W-1:0] LEN_ONE = LEN_W'(1);

  tenure_st_e       state_q;
  logic [LEN_W-1:0] len_q;
  logic             lost_q;
  logic             start_q;
  logic             rel_q;
  logic [LEN_W-1:0] rel_cnt_q;
  logic             rel_cut_q;

  logic             go;
  logic             owned;
  logic             take;
  logic             lost_now;
  logic             beat;
  logic             stop;
  logic             lat_expired;
  logic [LAT_W-1:0] lat_cnt;
  logic [LEN_W-1:0] beats_cnt;
  logic [LEN_W-1:0] beats_next;
  logic             beats_last;

  assign owned    = (state_q == ST_XFER);
  assign take     = (state_q == ST_IDLE) && req_valid_i;
  assign beat     = owned && tgt_ready_i;
  assign lost_now = lost_q || !gnt_i;
  assign stop     = beat && (beats_last || (lost_now && lat_expired));

  tenure_start_gate u_gate (
    .armed_i     (state_q == ST_WAIT),
    .gnt_i       (gnt_i),
    .bus_frame_i (bus_frame_i),
    .bus_rdy_i   (bus_rdy_i),
    .go_o        (go)
  );

  tenure_lat_counter #(.LAT_W(LAT_W)) u_lat (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (go),
    .load_val_i (lat_value_i),
    .run_i      (owned),
    .cnt_o      (lat_cnt),
    .expired_o  (lat_expired)
  );

  tenure_beat_counter #(.LEN_W(LEN_W)) u_beats (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (go),
    .beat_i  (beat),
    .len_i   (len_q),
    .count_o (beats_cnt),
    .next_o  (beats_next),
    .last_o  (beats_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      len_q     <= LEN_ONE;
      lost_q    <= 1'b0;
      start_q   <= 1'b0;
      rel_q     <= 1'b0;
      rel_cnt_q <= '0;
      rel_cut_q <= 1'b0;
    end else begin
      start_q <= go;
      rel_q   <= stop;
      case (state_q)
        ST_IDLE: if (take) begin
          len_q   <= (req_len_i == '0) ? LEN_ONE : req_len_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (go) begin
          lost_q  <= 1'b0;
          state_q <= ST_XFER;
        end
        ST_XFER: begin
          lost_q <= lost_now;
          if (stop) begin
            state_q   <= ST_IDLE;
            rel_cnt_q <= beats_next;
            rel_cut_q <= !beats_last;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign start_o     = start_q;
  assign frame_o     = owned;
  assign release_o   = rel_q;
  assign rel_count_o = rel_cnt_q;
  assign rel_cut_o   = rel_cut_q;

  // R1: never ready while the bus is owned
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready_o |-> !frame_o);
  // R2: a start follows an edge with grant and an idle bus
  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(gnt_i && !bus_frame_i && !bus_rdy_i));
  // R2: frame rises only together with the start pulse
  assert_frame_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_o) |-> start_o);
  // R9: release is a single pulse after the frame ends
  assert_rel_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |=> !release_o);
  assert_rel_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (!frame_o && $past(frame_o)));
  // R5: reported count is nonzero and never above the request
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    release_o |-> (rel_count_o != '0 && rel_count_o <= len_q));
  // R8: a cut burst always had its grant withdrawn
  assert_cut_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (release_o && rel_cut_o) |-> lost_q);
  // R6: with the counter expired and grant lost, a completed phase ends the tenure
  assert_expired_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && tgt_ready_i && lost_now && lat_cnt == '0) |=> (release_o && !frame_o));
  // R10: a stalled phase keeps the frame
  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (owned && !tgt_ready_i) |=> frame_o);
  // R5: the count never passes the request while owned
  assert_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
    owned |-> beats_cnt < len_q);
endmodule

// File: tb/tenure_ctrl_tb_top.sv
module tenure_ctrl_tb_top;
  localparam int LEN_W = 8;
  localparam int LAT_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid_i = 1'b0;
  logic             req_ready_o;
  logic [LEN_W-1:0] req_len_i = '0;
  logic [LAT_W-1:0] lat_value_i = '0;
  logic             gnt_i = 1'b1;
  logic             bus_frame_i = 1'b0;
  logic             bus_rdy_i = 1'b0;
  logic             tgt_ready_i = 1'b1;
  logic             start_o, frame_o, release_o, rel_cut_o;
  logic [LEN_W-1:0] rel_count_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  tenure_ctrl #(.LEN_W(LEN_W), .LAT_W(LAT_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_len_i(req_len_i),
    .lat_value_i(lat_value_i), .gnt_i(gnt_i), .bus_frame_i(bus_frame_i),
    .bus_rdy_i(bus_rdy_i), .tgt_ready_i(tgt_ready_i),
    .start_o(start_o), .frame_o(frame_o), .release_o(release_o),
    .rel_count_o(rel_count_o), .rel_cut_o(rel_cut_o)
  );

  // Behavioural reference: 0 idle, 1 waiting, 2 owning
  int m_mode = 0, m_len = 1, m_tenure = 0, m_done = 0;
  bit m_lost = 0, m_start = 0, m_rel = 0, m_cut = 0;
  int m_cnt = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_len = 1; m_tenure = 0; m_done = 0; m_lost = 0;
      m_start = 0; m_rel = 0; m_cut = 0; m_cnt = 0;
    end else begin
      m_start = 0;
      m_rel   = 0;
      if (m_mode == 0) begin
        if (req_valid_i) begin
          m_len  = (req_len_i == 0) ? 1 : int'(req_len_i);
          m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (gnt_i && !bus_frame_i && !bus_rdy_i) begin
          m_mode = 2; m_start = 1; m_tenure = int'(lat_value_i);
          m_done = 0; m_lost = 0;
        end
      end else begin
        bit gone;
        bit finish;
        gone   = m_lost || !gnt_i;
        finish = 0;
        if (tgt_ready_i) begin
          m_done = m_done + 1;
          if (m_done == m_len || (gone && m_tenure == 0)) finish = 1;
        end
        if (m_tenure > 0) m_tenure = m_tenure - 1;
        m_lost = gone;
        if (finish) begin
          m_mode = 0; m_rel = 1; m_cnt = m_done; m_cut = (m_done != m_len);
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      check(req_ready_o == (m_mode == 0), "R1", "req_ready_o", req_ready_o, m_mode == 0);
      check(start_o == m_start, "R2", "start_o", start_o, m_start);
      check(frame_o == (m_mode == 2), "R5", "frame_o", frame_o, m_mode == 2);
      check(release_o == m_rel, "R9", "release_o", release_o, m_rel);
      check(int'(rel_count_o) == m_cnt, "R9", "rel_count_o", rel_count_o, m_cnt);
      check(rel_cut_o == m_cut, "R9", "rel_cut_o", rel_cut_o, m_cut);
    end
  end

  task automatic finish_up();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic issue(input int len, input int lat);
    req_len_i = LEN_W'(len);
    lat_value_i = LAT_W'(lat);
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
  endtask

  task automatic wait_start();
    while (!start_o) @(negedge clk);
  endtask

  task automatic expect_rel(input int cnt, input bit cut, input string tag);
    while (!release_o) @(negedge clk);
    check(int'(rel_count_o) == cnt, tag, "released count", rel_count_o, cnt);
    check(rel_cut_o == cut, tag, "cut flag", rel_cut_o, cut);
    @(negedge clk);
    gnt_i = 1'b1;
    tgt_ready_i = 1'b1;
  endtask

  initial begin
    @(negedge clk);
    // Reset state
    check(req_ready_o == 1'b1, "R1", "reset ready", req_ready_o, 1);
    check(frame_o == 1'b0 && start_o == 1'b0 && release_o == 1'b0, "R9", "reset outputs", frame_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: plain burst of 4
    issue(4, 10);
    check(req_ready_o == 1'b0, "R1", "busy after accept", req_ready_o, 0);
    expect_rel(4, 0, "R5");

    // R3: busy bus and missing grant hold the start off, then R2 starts
    bus_frame_i = 1'b1;
    issue(2, 4);
    for (int i = 0; i < 4; i++) begin
      check(!start_o && !frame_o, "R3", "no start while frame busy", start_o, 0);
      @(negedge clk);
    end
    bus_frame_i = 1'b0; bus_rdy_i = 1'b1;
    for (int i = 0; i < 3; i++) begin
      check(!start_o && !frame_o, "R3", "no start while ready busy", start_o, 0);
      @(negedge clk);
    end
    bus_rdy_i = 1'b0; gnt_i = 1'b0;
    for (int i = 0; i < 3; i++) begin
      check(!start_o && !frame_o, "R3", "no start without grant", start_o, 0);
      @(negedge clk);
    end
    gnt_i = 1'b1;
    @(negedge clk);
    check(start_o && frame_o, "R2", "start with grant on idle bus", start_o, 1);
    expect_rel(2, 0, "R2");

    // R1: zero length counts as one; a request offered while owning is dropped
    issue(0, 3);
    expect_rel(1, 0, "R1");
    issue(5, 9);
    wait_start();
    req_valid_i = 1'b1; req_len_i = 8'd7;
    @(negedge clk);
    req_valid_i = 1'b0;
    expect_rel(5, 0, "R1");
    check(req_ready_o == 1'b1, "R1", "ready after release", req_ready_o, 1);

    // R6: tenure 0, grant lost in third owned cycle
    issue(8, 0);
    wait_start();
    @(negedge clk);
    @(negedge clk);
    gnt_i = 1'b0;
    expect_rel(3, 1, "R6");

    // R7: tenure 5, grant lost at once: six phases
    issue(20, 5);
    wait_start();
    gnt_i = 1'b0;
    expect_rel(6, 1, "R7");

    // R8: short grant dip is remembered: tenure 3 gives four phases
    issue(10, 3);
    wait_start();
    gnt_i = 1'b0;
    @(negedge clk);
    gnt_i = 1'b1;
    expect_rel(4, 1, "R8");

    // R4: counter runs out during a full burst, stays at zero
    issue(10, 2);
    expect_rel(10, 0, "R4");
    issue(10, 2);
    wait_start();
    repeat (5) @(negedge clk);
    gnt_i = 1'b0;
    expect_rel(6, 1, "R4");

    // R10: stalled phases keep the frame and are not counted
    tgt_ready_i = 1'b0;
    issue(3, 9);
    wait_start();
    @(negedge clk);
    @(negedge clk);
    check(frame_o == 1'b1, "R10", "frame held in stall", frame_o, 1);
    tgt_ready_i = 1'b1;
    @(negedge clk);
    tgt_ready_i = 1'b0;
    @(negedge clk);
    tgt_ready_i = 1'b1;
    expect_rel(3, 0, "R10");

    // R10 with R6: stalled phase under lost grant waits for completion
    tgt_ready_i = 1'b0;
    issue(6, 0);
    wait_start();
    gnt_i = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(frame_o == 1'b1, "R10", "frame held until phase completes", frame_o, 1);
    tgt_ready_i = 1'b1;
    expect_rel(1, 1, "R6");

    repeat (3) @(negedge clk);
    finish_up();
  end
endmodule